// File: doc/BRIEF.md
# General-Purpose I/O Port with Pin Ownership Arbitration

This block is one byte-wide general-purpose I/O port driven through a small register interface. Software sets, per pin, an output latch, a direction, and three pad-control bits: pull-up enable, slew-rate limiting and high drive. The three pad-control bits go straight out to the pad cells unchanged.

Each pin has three possible owners. An analog function wins over everything. An alternate digital peripheral comes next. Plain GPIO is used only when neither of the others is enabled. The owner decides the pad's output value, output enable and input-buffer enable.

The port-data read path depends on the direction bit alone, whoever owns the pin. An output bit reads back its latch. An input bit reads the pin level after it has passed through a synchronizer, and reads 0 when its input buffer is switched off. Register writes and reads each take a single cycle. Reads are combinational from the address.

Top module: `gpio_port`

## Requirements
- R1: After reset, all five registers read 0. Every pad output-enable, pull, slew and drive output is then 0 while no peripheral or analog function is enabled.
- R2: A write with `wr_en` high updates, at the next clock edge, the register selected by `addr`. The offsets are 0 data latch, 1 direction (1 = output), 2 pull-up enable, 3 slew enable and 4 high drive. Reads return that register's value in the same cycle. Offsets 5 to 7 read 0, and a write to them changes no register.
- R3: `pad_pull`, `pad_slew` and `pad_drive` always equal the registers at offsets 2, 3 and 4.
- R4: On a pin with neither the peripheral nor the analog function enabled, the pad has these values: output enable equals the direction bit, output value equals the data latch, and input enable is 1.
- R5: On a pin with `per_en` set and `ana_en` clear, the pad has these values: output enable equals `per_oe`, output value equals `per_out`, and input enable is 1.
- R6: On a pin with `ana_en` set, the pad has output enable 0, input enable 0 and output value 0, even when `per_en` is also set.
- R7: A read of offset 0 returns, for each bit whose direction is 1, that bit's data latch.
- R8: A read of offset 0 returns, for each input bit whose input buffer is enabled, the `pad_in` level seen two clock edges earlier. One edge after a change, the read still shows the old level.
- R9: A read of offset 0 returns 0 for each input bit whose `ana_en` is set.
- R10: The direction bit selects the read source (R7 or R8) even while the peripheral owns the pin.
- R11: A write to offset 0 updates the data latch whatever the direction, peripheral and analog settings. The new value then appears on the pad once the pin becomes a GPIO output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| per_en | input | 8 | Per-pin peripheral enable |
| per_oe | input | 8 | Peripheral output enable |
| per_out | input | 8 | Peripheral output value |
| ana_en | input | 8 | Per-pin analog function enable |
| pad_in | input | 8 | Pin levels from pads |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output-buffer enable |
| pad_ie | output | 8 | Pad input-buffer enable |
| pad_pull | output | 8 | Pad pull-up enable |
| pad_slew | output | 8 | Pad slew-rate enable |
| pad_drive | output | 8 | Pad high-drive select |

## Verification
The bench builds the port with its default parameters: eight pins and a two-stage synchronizer. Eight pins allow direction, peripheral and analog masks that split the byte into every ownership combination within a single pattern. The two-stage depth makes the one-edge-late and two-edge-valid sampling points on the input read path distinct and checkable.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_PULL  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_SLEW  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_DRIVE = 3'd4;

    typedef enum logic [1:0] {
        OWN_GPIO   = 2'd0,
        OWN_PERIPH = 2'd1,
        OWN_ANALOG = 2'd2
    } owner_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      latch_o,
    output logic [W-1:0]      dir_o,
    output logic [W-1:0]      pull_o,
    output logic [W-1:0]      slew_o,
    output logic [W-1:0]      drive_o
);
    typedef struct packed {
        logic [W-1:0] latch;
        logic [W-1:0] dir;
        logic [W-1:0] pull;
        logic [W-1:0] slew;
        logic [W-1:0] drive;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (addr)
                OFS_DATA:  st_d.latch = wdata;
                OFS_DIR:   st_d.dir   = wdata;
                OFS_PULL:  st_d.pull  = wdata;
                OFS_SLEW:  st_d.slew  = wdata;
                OFS_DRIVE: st_d.drive = wdata;
                default:   st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch_o = st_q.latch;
    assign dir_o   = st_q.dir;
    assign pull_o  = st_q.pull;
    assign slew_o  = st_q.slew;
    assign drive_o = st_q.drive;

    assert_wr_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_DIR) |=> (dir_o == $past(wdata)));

    assert_unmapped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > OFS_DRIVE) |=> $stable(st_q));

    assert_latch_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_DATA) |=> (latch_o == $past(wdata)));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d    = chain_q;
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pin.sv
module gpio_pin
    import gpio_pkg::*;
(
    input  logic latch_i,
    input  logic dir_i,
    input  logic per_en_i,
    input  logic per_oe_i,
    input  logic per_out_i,
    input  logic ana_en_i,
    input  logic sync_i,
    output logic pad_out_o,
    output logic pad_oe_o,
    output logic pad_ie_o,
    output logic rd_bit_o
);
    owner_e owner;

    always_comb begin
        if (ana_en_i)      owner = OWN_ANALOG;
        else if (per_en_i) owner = OWN_PERIPH;
        else               owner = OWN_GPIO;
    end

    always_comb begin
        pad_out_o = 1'b0;
        pad_oe_o  = 1'b0;
        pad_ie_o  = 1'b1;
        case (owner)
            OWN_ANALOG: begin
                pad_ie_o = 1'b0;
            end
            OWN_PERIPH: begin
                pad_out_o = per_out_i;
                pad_oe_o  = per_oe_i;
            end
            default: begin
                pad_out_o = latch_i;
                pad_oe_o  = dir_i;
            end
        endcase
    end

    always_comb begin
        if (dir_i)         rd_bit_o = latch_i;
        else if (pad_ie_o) rd_bit_o = sync_i;
        else               rd_bit_o = 1'b0;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata,
    input  logic [WIDTH-1:0]  per_en,
    input  logic [WIDTH-1:0]  per_oe,
    input  logic [WIDTH-1:0]  per_out,
    input  logic [WIDTH-1:0]  ana_en,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_ie,
    output logic [WIDTH-1:0]  pad_pull,
    output logic [WIDTH-1:0]  pad_slew,
    output logic [WIDTH-1:0]  pad_drive
);
    logic [WIDTH-1:0] latch_w, dir_w, pull_w, slew_w, drive_w;
    logic [WIDTH-1:0] sync_w, rd_port_w;

    gpio_regs #(.W(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .latch_o (latch_w),
        .dir_o   (dir_w),
        .pull_o  (pull_w),
        .slew_o  (slew_w),
        .drive_o (drive_w)
    );

    gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (sync_w)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        gpio_pin u_pin (
            .latch_i   (latch_w[i]),
            .dir_i     (dir_w[i]),
            .per_en_i  (per_en[i]),
            .per_oe_i  (per_oe[i]),
            .per_out_i (per_out[i]),
            .ana_en_i  (ana_en[i]),
            .sync_i    (sync_w[i]),
            .pad_out_o (pad_out[i]),
            .pad_oe_o  (pad_oe[i]),
            .pad_ie_o  (pad_ie[i]),
            .rd_bit_o  (rd_port_w[i])
        );
    end

    always_comb begin
        case (addr)
            OFS_DATA:  rdata = rd_port_w;
            OFS_DIR:   rdata = dir_w;
            OFS_PULL:  rdata = pull_w;
            OFS_SLEW:  rdata = slew_w;
            OFS_DRIVE: rdata = drive_w;
            default:   rdata = '0;
        endcase
    end

    assign pad_pull  = pull_w;
    assign pad_slew  = slew_w;
    assign pad_drive = drive_w;

    assert_analog_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ana_en & (pad_oe | pad_ie | pad_out)) == '0));

    assert_gpio_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~per_en & ~ana_en) == (dir_w & ~per_en & ~ana_en)));

    assert_periph_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & per_en & ~ana_en) == (per_out & per_en & ~ana_en)));

    assert_ana_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_DATA) |-> ((rdata & ~dir_w & ana_en) == '0));

    assert_out_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_DATA) |-> ((rdata & dir_w) == (latch_w & dir_w)));
endmodule

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] per_en = '0, per_oe = '0, per_out = '0, ana_en = '0, pad_in = '0;
    logic [7:0] pad_out, pad_oe, pad_ie, pad_pull, pad_slew, pad_drive;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    gpio_port uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .per_en(per_en), .per_oe(per_oe), .per_out(per_out),
        .ana_en(ana_en), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_ie(pad_ie), .pad_pull(pad_pull), .pad_slew(pad_slew),
        .pad_drive(pad_drive)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        #1;
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_pull", pad_pull, 8'h00);
        check("R1 pad_slew", pad_slew, 8'h00);
        check("R1 pad_drive", pad_drive, 8'h00);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check("R1 reg read", v, 8'h00);
        end
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(3'd1, 8'h96); wr(3'd2, 8'h11); wr(3'd3, 8'h22); wr(3'd4, 8'h44);
        rd(3'd1, v); check("R2 dir readback", v, 8'h96);
        rd(3'd2, v); check("R2 pull readback", v, 8'h11);
        rd(3'd3, v); check("R2 slew readback", v, 8'h22);
        rd(3'd4, v); check("R2 drive readback", v, 8'h44);
        check("R3 pad_pull", pad_pull, 8'h11);
        check("R3 pad_slew", pad_slew, 8'h22);
        check("R3 pad_drive", pad_drive, 8'h44);
        wr(3'd5, 8'hFF); wr(3'd7, 8'hFF);
        rd(3'd5, v); check("R2 unmapped read", v, 8'h00);
        rd(3'd1, v); check("R2 unmapped write ignored dir", v, 8'h96);
        rd(3'd4, v); check("R2 unmapped write ignored drive", v, 8'h44);
        check("R3 pad_pull after unmapped", pad_pull, 8'h11);
    endtask

    task automatic t_gpio_out();
        logic [7:0] v;
        pad_in = 8'h00;
        wr(3'd1, 8'hF0); wr(3'd0, 8'hA5);
        settle(3);
        #1;
        check("R4 pad_oe", pad_oe, 8'hF0);
        check("R4 pad_out", pad_out, 8'hA5);
        check("R4 pad_ie", pad_ie, 8'hFF);
        rd(3'd0, v); check("R7 read output bits", v, 8'hA0);
    endtask

    task automatic t_sync();
        logic [7:0] v;
        wr(3'd1, 8'h00);
        addr = 3'd0;
        @(negedge clk);
        pad_in = 8'h3C;
        @(posedge clk); #1;
        check("R8 one edge late", rdata, 8'h00);
        @(posedge clk); #1;
        check("R8 two edges valid", rdata, 8'h3C);
        rd(3'd0, v);
        check("R8 held", v, 8'h3C);
    endtask

    task automatic t_periph();
        logic [7:0] v;
        wr(3'd1, 8'hF0);
        @(negedge clk);
        per_en = 8'h0F; per_oe = 8'h05; per_out = 8'h03;
        #1;
        check("R5 pad_oe", pad_oe, 8'hF5);
        check("R5 pad_out", pad_out, 8'hA3);
        check("R5 pad_ie", pad_ie, 8'hFF);
        rd(3'd0, v); check("R10 read dir=F0 with periph", v, 8'hAC);
        wr(3'd1, 8'h0F);
        rd(3'd0, v); check("R10 read dir=0F with periph", v, 8'h35);
    endtask

    task automatic t_analog();
        logic [7:0] v;
        wr(3'd1, 8'hF0);
        @(negedge clk);
        ana_en = 8'h33;
        #1;
        check("R6 pad_oe", pad_oe, 8'hC4);
        check("R6 pad_ie", pad_ie, 8'hCC);
        check("R6 pad_out", pad_out, 8'h80);
        rd(3'd0, v); check("R9 analog input bits read 0", v, 8'hAC);
    endtask

    task automatic t_latch();
        logic [7:0] v;
        @(negedge clk);
        ana_en = 8'hFF; per_en = 8'h00;
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h5A);
        rd(3'd0, v); check("R9 all analog inputs read 0", v, 8'h00);
        check("R6 all analog pad_ie", pad_ie, 8'h00);
        @(negedge clk);
        ana_en = 8'h00;
        wr(3'd1, 8'hFF);
        rd(3'd0, v); check("R11 latch kept through analog", v, 8'h5A);
        check("R11 pad_out", pad_out, 8'h5A);
        check("R4 pad_oe all out", pad_oe, 8'hFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        settle(1);
        t_reset();
        t_regs();
        t_gpio_out();
        t_sync();
        t_periph();
        t_analog();
        t_latch();
        settle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule